// File: doc/BRIEF.md
# SDRAM Row Boundary Decoder

This block turns a 32-bit physical address into a chip select for one of four SDRAM rows. Software sets up the memory map by writing one 8-bit cumulative upper limit per row through a small register port. Each limit holds address bits 31:24, so the map moves in 16 MB steps. Rows are packed end to end. Row 0 starts at address zero, and every later row starts at the limit of the row before it. A row whose limit does not go past the limit before it holds no memory and is never chosen.

The address path is purely combinational. It gives a one-hot chip-select vector and a hit flag, and it also reports the base and the limit of the row it chose, so a following stage can form the offset inside the row. A single global flag records whether the installed modules are registered or unbuffered, because the two kinds may not be mixed. The register port also reads back every stored value.

Top module: `rowdec_top`

## Requirements
- R1: After reset all four row limits read 0, the module-type flag reads 0, and every address misses: `hit` is 0, `chipSel` is 0, and `rowBase` and `rowLimit` are 0.
- R2: A write with `cfgWrEn` high and `cfgAddr` 0 to 3 stores `cfgWrData` as that row's limit at the next rising clock. `cfgRdData` shows the old value before that edge and the new value after it.
- R3: Index 4 of the register port holds the global module-type flag in data bit 0 (1 means registered, 0 means unbuffered). It is driven on `regModules` and reads back as `{7'b0, flag}`.
- R4: Row 0 has base 0. Row i>0 has as its base the limit of row i-1. `rowBase` and `rowLimit` carry the chosen row's 8-bit base and limit in bits 31:24, with bits 23:0 set to zero.
- R5: An address selects a row when base[31:24] <= addr[31:24] < limit[31:24]. `chipSel[i]` drives row i.
- R6: A row whose limit is less than or equal to its base is empty and is never selected, whatever the address.
- R7: An address matched by no row gives `hit`=0, `chipSel`=0, `rowBase`=0 and `rowLimit`=0. Addresses at or above the limit of the last populated row are one such case.
- R8: When several rows match (limits that are not monotonic), the lowest-numbered matching row wins.
- R9: `chipSel` is one-hot or all zero, and `hit` equals the OR of `chipSel`.
- R10: Writes to indices 5 to 7 change no stored value, and reads from those indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register write index |
| cfgWrData | input | 8 | Register write data |
| cfgRdAddr | input | 3 | Register read index |
| cfgRdData | output | 8 | Register read data |
| addr | input | 32 | Physical address to decode |
| chipSel | output | 4 | One-hot row select |
| hit | output | 1 | Address falls in a populated row |
| rowBase | output | 32 | Base address of the chosen row |
| rowLimit | output | 32 | Limit address of the chosen row |
| regModules | output | 1 | Global registered-module flag |

## Verification
The decode holds no state of its own, so a wrong stored limit or a wrong type flag shows up at the ports in the first cycle after the write edge. It appears either through readback or as a row boundary moving by 16 MB, and the checks therefore probe the addresses just below and just at each boundary. A wrong priority or a wrong empty-row rule can only be seen when limits repeat or decrease, so those layouts are programmed on purpose and probed at addresses that more than one row could claim.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;
  localparam int ROWS = 4;

  typedef struct packed {
    logic [ROWS-1:0] limWr;
    logic            typeWr;
  } rowdec_stb_t;
endpackage

// File: rtl/rowdec_ctrl.sv
module rowdec_ctrl
  import rowdec_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgAddr,
  output rowdec_stb_t      stb
);
  localparam int TYPE_IDX = ROWS;

  always_comb begin
    stb = '0;
    if (cfgWrEn) begin
      for (int i = 0; i < ROWS; i++) begin
        if (int'(cfgAddr) == i) stb.limWr[i] = 1'b1;
      end
      if (int'(cfgAddr) == TYPE_IDX) stb.typeWr = 1'b1;
    end
  end

  // R10: an index above the type slot raises no strobe
  assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (int'(cfgAddr) > TYPE_IDX) |-> (stb == '0));
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stb) <= 1);
endmodule

// File: rtl/rowdec_pick.sv
module rowdec_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] match,
  output logic [N-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rowdec_dp.sv
module rowdec_dp
  import rowdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rowdec_stb_t       stb,
  input  logic [LIM_W-1:0]  wrData,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [LIM_W-1:0]  rdData,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROWS-1:0]   chipSel,
  output logic              hit,
  output logic [ADDR_W-1:0] rowBase,
  output logic [ADDR_W-1:0] rowLimit,
  output logic              regModules
);
  localparam int LOW_W = ADDR_W - LIM_W;

  logic [LIM_W-1:0] limReg  [ROWS];
  logic [LIM_W-1:0] baseOf  [ROWS];
  logic [ROWS-1:0]  populated;
  logic [ROWS-1:0]  match;
  logic [ROWS-1:0]  grant;
  logic             typeReg;
  logic [LIM_W-1:0] addrTop;
  logic [LIM_W-1:0] selBase;
  logic [LIM_W-1:0] selLim;

  assign addrTop = addr[ADDR_W-1:LOW_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) limReg[i] <= '0;
      typeReg <= 1'b0;
    end else begin
      for (int i = 0; i < ROWS; i++) begin
        if (stb.limWr[i]) limReg[i] <= wrData;
      end
      if (stb.typeWr) typeReg <= wrData[0];
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : gRow
    if (g == 0) begin : gFirst
      assign baseOf[g] = '0;
    end else begin : gNext
      assign baseOf[g] = limReg[g-1];
    end
    assign populated[g] = limReg[g] > baseOf[g];
    assign match[g]     = populated[g] && (addrTop >= baseOf[g]) && (addrTop < limReg[g]);
  end

  rowdec_pick #(.N(ROWS)) i_pick (.match(match), .grant(grant));

  always_comb begin
    selBase = '0;
    selLim  = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (grant[i]) begin
        selBase = selBase | baseOf[i];
        selLim  = selLim  | limReg[i];
      end
    end
  end

  assign chipSel    = grant;
  assign hit        = |grant;
  assign rowBase    = {selBase, {LOW_W{1'b0}}};
  assign rowLimit   = {selLim,  {LOW_W{1'b0}}};
  assign regModules = typeReg;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (int'(rdAddr) == i) rdData = limReg[i];
    end
    if (int'(rdAddr) == ROWS) rdData = {{(LIM_W-1){1'b0}}, typeReg};
  end

  assert_onehot_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chipSel));
  assert_hit_matches_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    hit == (chipSel != '0));
  assert_addr_in_row_R5: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (addr >= rowBase) && (addr < rowLimit));
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (rowBase == '0) && (rowLimit == '0));
  assert_nonempty_row_R6: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (rowLimit > rowBase));
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.limWr[0] |=> (limReg[0] == $past(wrData)));
endmodule

// File: rtl/rowdec_top.sv
module rowdec_top
  import rowdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgAddr,
  input  logic [LIM_W-1:0]  cfgWrData,
  input  logic [IDX_W-1:0]  cfgRdAddr,
  output logic [LIM_W-1:0]  cfgRdData,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROWS-1:0]   chipSel,
  output logic              hit,
  output logic [ADDR_W-1:0] rowBase,
  output logic [ADDR_W-1:0] rowLimit,
  output logic              regModules
);
  rowdec_stb_t stb;

  rowdec_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .stb(stb)
  );

  rowdec_dp #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cfgWrData),
    .rdAddr(cfgRdAddr), .rdData(cfgRdData), .addr(addr),
    .chipSel(chipSel), .hit(hit), .rowBase(rowBase), .rowLimit(rowLimit),
    .regModules(regModules)
  );
endmodule

// File: tb/test_rowdec_top.sv
module test_rowdec_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [2:0]  cfgRdAddr = '0;
  logic [7:0]  cfgRdData;
  logic [31:0] addr = '0;
  logic [3:0]  chipSel;
  logic        hit;
  logic [31:0] rowBase;
  logic [31:0] rowLimit;
  logic        regModules;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0]  cs;
    logic        hit;
    logic [31:0] base;
    logic [31:0] lim;
    logic [7:0]  rd;
    string       tag;
  } item_t;

  item_t expQ[$];
  logic [7:0] shLim [4];
  logic       shType;

  always #10 clk = ~clk;

  rowdec_top i_rowdec_top (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData),
    .addr(addr), .chipSel(chipSel), .hit(hit), .rowBase(rowBase),
    .rowLimit(rowLimit), .regModules(regModules)
  );

  function automatic item_t model(logic [31:0] a, logic [2:0] r, string tag);
    item_t e;
    logic [7:0] prev;
    e.cs = '0; e.hit = 1'b0; e.base = '0; e.lim = '0; e.tag = tag;
    prev = 8'h00;
    for (int i = 0; i < 4; i++) begin
      if (!e.hit && shLim[i] > prev && a[31:24] >= prev && a[31:24] < shLim[i]) begin
        e.hit = 1'b1; e.cs = 4'(1 << i);
        e.base = {prev, 24'h0}; e.lim = {shLim[i], 24'h0};
      end
      prev = shLim[i];
    end
    if (r < 3'd4) e.rd = shLim[r[1:0]];
    else if (r == 3'd4) e.rd = {7'b0, shType};
    else e.rd = 8'h00;
    return e;
  endfunction

  task automatic compare(item_t e);
    checks++;
    if (chipSel !== e.cs || hit !== e.hit || rowBase !== e.base ||
        rowLimit !== e.lim || cfgRdData !== e.rd || regModules !== shType) begin
      fails++;
      $display("FAIL %s: cs=%b hit=%b base=%h lim=%h rd=%h type=%b exp cs=%b hit=%b base=%h lim=%h rd=%h type=%b",
               e.tag, chipSel, hit, rowBase, rowLimit, cfgRdData, regModules,
               e.cs, e.hit, e.base, e.lim, e.rd, shType);
    end
  endtask

  // Monitor: results are combinational, compared 5 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  task automatic probe(logic [31:0] a, logic [2:0] r, string tag);
    @(negedge clk);
    addr = a;
    cfgRdAddr = r;
    expQ.push_back(model(a, r, tag));
  endtask

  // Write a register; before the edge the readback must still show the old value (R2).
  task automatic writeReg(logic [2:0] idx, logic [7:0] d);
    item_t e;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = idx; cfgWrData = d; cfgRdAddr = idx;
    #5;
    e = model(addr, idx, "R2 value before write edge");
    compare(e);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (idx < 3'd4) shLim[idx[1:0]] = d;
    else if (idx == 3'd4) shType = d[0];
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) shLim[i] = 8'h00;
    shType = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    probe(32'h0000_0000, 3'd0, "R1 reset limit0 and miss");
    probe(32'h7000_0000, 3'd4, "R1 reset type flag");
    probe(32'hFFFF_FFFF, 3'd3, "R1 reset limit3");

    // Layout: 0x02, 0x04, 0x04 (row 2 empty), 0x0C
    writeReg(3'd0, 8'h02);
    writeReg(3'd1, 8'h04);
    writeReg(3'd2, 8'h04);
    writeReg(3'd3, 8'h0C);
    writeReg(3'd4, 8'h01);
    probe(32'h0000_0000, 3'd0, "R2 readback limit0");
    probe(32'h0000_0000, 3'd1, "R2 readback limit1");
    probe(32'h0000_0000, 3'd3, "R2 readback limit3");
    probe(32'h0000_0000, 3'd4, "R3 type flag set");
    probe(32'h01FF_FFFF, 3'd0, "R5 R4 top of row0");
    probe(32'h0200_0000, 3'd0, "R5 R4 bottom of row1");
    probe(32'h03FF_FFFF, 3'd0, "R5 top of row1");
    probe(32'h0400_0000, 3'd2, "R6 empty row2 skipped to row3");
    probe(32'h0BFF_FFFF, 3'd0, "R5 top of row3");
    probe(32'h0C00_0000, 3'd0, "R7 at last limit misses");
    probe(32'hFFFF_FFFF, 3'd0, "R7 top of space misses");

    // R10 ignored indices
    writeReg(3'd5, 8'hAA);
    writeReg(3'd7, 8'h55);
    for (int r = 0; r < 6; r++) probe(32'h0500_0000, 3'(r), "R10 stray write left state");
    writeReg(3'd4, 8'h00);
    probe(32'h0000_0000, 3'd4, "R3 type flag cleared");

    // R8 non-monotonic: 0x04, 0x02 (empty), 0x08, 0x08 (empty)
    writeReg(3'd0, 8'h04);
    writeReg(3'd1, 8'h02);
    writeReg(3'd2, 8'h08);
    writeReg(3'd3, 8'h08);
    probe(32'h0300_0000, 3'd0, "R8 row0 beats row2");
    probe(32'h0100_0000, 3'd1, "R6 R8 row1 empty row0 wins");
    probe(32'h0500_0000, 3'd2, "R8 R4 row2 base from row1");
    probe(32'h0800_0000, 3'd3, "R7 above all rows");

    // Full range at top of space
    writeReg(3'd3, 8'hFF);
    probe(32'hFEFF_FFFF, 3'd3, "R5 R9 last 16MB below max limit");
    probe(32'hFF00_0000, 3'd3, "R7 max limit boundary");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, exp 0", expQ.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule